// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Bank

This block receives message-signalled interrupts as plain 32-bit register writes. An upstream agent stores an interrupt number into one doorbell register. The block splits that number into two fields. One field chooses a shared 32-bit pending word and the other picks one bit inside it. The chosen bit is then set. Every pending word drives its own level interrupt line toward a parent interrupt controller. The line stays high while any bit in that word is pending.

The service routine reads a pending word to learn which sources fired. That read also acknowledges them: the word is cleared in the same cycle, so no separate end-of-interrupt write exists. Three static straps choose the variant. One picks how the doorbell payload is split into fields. One picks the register spacing and the doorbell location. One reverses the byte order of the payload before decoding, to work around an endian erratum in the upstream writer. The straps may only change while reset is held.

The register port has separate read and write address buses, so a doorbell write and a clearing read can fall in the same cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `msi_doorbell_bank`

## Requirements
- R1: With `layout_alt_i`=0, a doorbell write sets bit `payload[4:0]` of pending word `payload[8:5]`.
- R2: With `layout_alt_i`=1, a doorbell write sets bit `payload[8:4]` of pending word `payload[3:0]`.
- R3: With `swap_i`=1, the payload is byte-reversed before decoding (byte 0 swaps with byte 3, byte 1 swaps with byte 2).
- R4: With `narrow_i`=0, pending word n sits at byte address n*0x10 for n in 0..15, and the doorbell sits at 0x140.
- R5: With `narrow_i`=1, pending word n sits at byte address n*0x4 for n in 0..7, and the doorbell sits at 0x38. A doorbell write that selects word 8 or above is ignored, and a write to 0x140 is not a doorbell write.
- R6: A read of a pending word returns its value on `rd_data_o` in the next cycle and clears the word. In any cycle with no read in the previous cycle, `rd_data_o` is zero.
- R7: `irq_o[n]` is high exactly when pending word n has at least one bit set.
- R8: When a doorbell write sets a bit in the same cycle that a read clears that word, the read returns the old value and the new bit stays pending.
- R9: Writes to pending-word addresses change nothing. A read of the doorbell address returns zero.
- R10: A synchronous active-high reset clears every pending word, every interrupt line and the read data.
- R11: Successive doorbell writes to one word accumulate their bits until that word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| layout_alt_i | input | 1 | Static strap: alternate payload field layout |
| narrow_i | input | 1 | Static strap: 4-byte register spacing, doorbell at 0x38 |
| swap_i | input | 1 | Static strap: byte-reverse the doorbell payload |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 12 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 12 | Read byte address |
| rd_data_o | output | 32 | Registered read data, valid one cycle after the strobe |
| irq_o | output | 16 | One level interrupt per pending word |

## Verification
The bench aims at the same-cycle collision of a doorbell write with a clearing read of the same word. A design that applies the clear after the set would lose that interrupt for good, and the second read would come back zero. It walks the address and field decode in every strap combination. A swapped field boundary or a wrong stride would set the wrong bit or word, and the per-cycle comparison of `irq_o` against the model would show it. In the narrow variant it sends select values beyond the eighth word and writes to the wide doorbell address. A design with a missing range check would raise an interrupt line that must stay low. Writes to pending-word addresses are followed by reads, so a design that let software overwrite a word would show non-zero data.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 4;
    localparam int IDX_W  = 5;

    typedef struct packed {
        logic [WORD_W-1:0] bits;
    } pend_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } port_state_t;

    function automatic logic [WORD_W-1:0] byte_reverse(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[b*8 +: 8] = w[(WORD_W/8 - 1 - b)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_bank_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_WORDS   = 16,
    parameter int NARROW_WORDS = 8,
    parameter int WIDE_DB     = 'h140,
    parameter int NARROW_DB   = 'h38
) (
    input  logic              narrow_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              db_hit_o,
    output logic              pend_hit_o,
    output logic [SEL_W-1:0]  pend_idx_o
);
    localparam logic [ADDR_W-1:0] WIDE_DB_A   = ADDR_W'(WIDE_DB);
    localparam logic [ADDR_W-1:0] NARROW_DB_A = ADDR_W'(NARROW_DB);
    localparam logic [ADDR_W-1:0] WIDE_CNT    = ADDR_W'(NUM_WORDS);
    localparam logic [ADDR_W-1:0] NARROW_CNT  = ADDR_W'(NARROW_WORDS);

    logic [ADDR_W-1:0] wide_slot;
    logic [ADDR_W-1:0] narrow_slot;

    always_comb begin
        wide_slot   = addr_i >> 4;
        narrow_slot = addr_i >> 2;
        if (narrow_i) begin
            db_hit_o   = (addr_i == NARROW_DB_A);
            pend_hit_o = (addr_i[1:0] == 2'b00) && (narrow_slot < NARROW_CNT) && !db_hit_o;
            pend_idx_o = SEL_W'(narrow_slot);
        end else begin
            db_hit_o   = (addr_i == WIDE_DB_A);
            pend_hit_o = (addr_i[3:0] == 4'h0) && (wide_slot < WIDE_CNT) && !db_hit_o;
            pend_idx_o = SEL_W'(wide_slot);
        end
    end

endmodule

// File: rtl/msi_payload_decode.sv
module msi_payload_decode
    import msi_bank_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  logic              swap_i,
    input  logic              layout_alt_i,
    input  logic [SEL_W:0]    word_count_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [WORD_W-1:0] bit_mask_o,
    output logic              in_range_o
);
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        word = swap_i ? byte_reverse(data_i) : data_i;
        if (layout_alt_i) begin
            sel_o = SEL_W'(word);
            idx   = IDX_W'(word >> SEL_W);
        end else begin
            idx   = IDX_W'(word);
            sel_o = SEL_W'(word >> IDX_W);
        end
        bit_mask_o = WORD_W'(1) << idx;
        in_range_o = ({1'b0, sel_o} < word_count_i);
    end

endmodule

// File: rtl/msi_pend_word.sv
module msi_pend_word
    import msi_bank_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              set_en_i,
    input  logic [WORD_W-1:0] set_mask_i,
    input  logic              rd_clr_i,
    output logic [WORD_W-1:0] bits_o,
    output logic              irq_o
);
    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr_i) st_d.bits = '0;
        if (set_en_i) st_d.bits = st_d.bits | set_mask_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign bits_o = st_q.bits;
    assign irq_o  = |st_q.bits;

    assert_clear_on_read_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_clr_i && !set_en_i) |=> (bits_o == '0));

    assert_set_survives_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        set_en_i |=> ((bits_o & $past(set_mask_i)) == $past(set_mask_i)));

    assert_accumulate_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (set_en_i && !rd_clr_i) |=> ((bits_o & $past(bits_o)) == $past(bits_o)));

    assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!set_en_i && !rd_clr_i) |=> $stable(bits_o));

    assert_irq_source_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> $past(set_en_i));

endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank
    import msi_bank_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int NUM_WORDS    = 16,
    parameter int NARROW_WORDS = 8,
    parameter int WIDE_DB      = 'h140,
    parameter int NARROW_DB    = 'h38
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 layout_alt_i,
    input  logic                 narrow_i,
    input  logic                 swap_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [WORD_W-1:0]    wr_data_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [WORD_W-1:0]    rd_data_o,
    output logic [NUM_WORDS-1:0] irq_o
);
    localparam logic [SEL_W:0] WIDE_COUNT   = (SEL_W+1)'(NUM_WORDS);
    localparam logic [SEL_W:0] NARROW_COUNT = (SEL_W+1)'(NARROW_WORDS);

    logic              wr_db_hit, wr_pend_hit;
    logic [SEL_W-1:0]  wr_pend_idx;
    logic              rd_db_hit, rd_pend_hit;
    logic [SEL_W-1:0]  rd_pend_idx;
    logic [SEL_W:0]    word_count;
    logic [SEL_W-1:0]  db_sel;
    logic [WORD_W-1:0] db_mask;
    logic              db_in_range;
    logic              db_fire;

    logic [WORD_W-1:0] pend_bits [NUM_WORDS];

    port_state_t ps_d, ps_q;

    assign word_count = narrow_i ? NARROW_COUNT : WIDE_COUNT;

    msi_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .NARROW_WORDS(NARROW_WORDS),
        .WIDE_DB(WIDE_DB), .NARROW_DB(NARROW_DB)
    ) u_wr_dec (
        .narrow_i   (narrow_i),
        .addr_i     (wr_addr_i),
        .db_hit_o   (wr_db_hit),
        .pend_hit_o (wr_pend_hit),
        .pend_idx_o (wr_pend_idx)
    );

    msi_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .NARROW_WORDS(NARROW_WORDS),
        .WIDE_DB(WIDE_DB), .NARROW_DB(NARROW_DB)
    ) u_rd_dec (
        .narrow_i   (narrow_i),
        .addr_i     (rd_addr_i),
        .db_hit_o   (rd_db_hit),
        .pend_hit_o (rd_pend_hit),
        .pend_idx_o (rd_pend_idx)
    );

    msi_payload_decode u_payload (
        .data_i       (wr_data_i),
        .swap_i       (swap_i),
        .layout_alt_i (layout_alt_i),
        .word_count_i (word_count),
        .sel_o        (db_sel),
        .bit_mask_o   (db_mask),
        .in_range_o   (db_in_range)
    );

    assign db_fire = wr_en_i && wr_db_hit && db_in_range;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic set_en, rd_clr;
        assign set_en = db_fire && (db_sel == SEL_W'(g));
        assign rd_clr = rd_en_i && rd_pend_hit && (rd_pend_idx == SEL_W'(g));

        msi_pend_word u_word (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .set_en_i   (set_en),
            .set_mask_i (db_mask),
            .rd_clr_i   (rd_clr),
            .bits_o     (pend_bits[g]),
            .irq_o      (irq_o[g])
        );
    end

    always_comb begin
        ps_d = '0;
        if (rd_en_i && rd_pend_hit) begin
            for (int n = 0; n < NUM_WORDS; n++) begin
                if (rd_pend_idx == SEL_W'(n)) ps_d.rdata = pend_bits[n];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ps_q <= '0;
        else       ps_q <= ps_d;
    end

    assign rd_data_o = ps_q.rdata;

    assert_doorbell_reads_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && rd_db_hit) |=> (rd_data_o == '0));

    assert_pend_write_ignored_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_pend_hit && !rd_en_i) |=> $stable(irq_o));

    assert_out_of_range_ignored_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_db_hit && !db_in_range && !rd_en_i) |=> $stable(irq_o));

    assert_idle_rdata_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> (rd_data_o == '0));

    assert_single_set_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (db_fire && !rd_en_i) |=> ($countones(irq_o & ~$past(irq_o)) <= 1));

endmodule

// File: tb/msi_doorbell_bank_tb.sv
module msi_doorbell_bank_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        layout_alt, narrow, swap;
    logic        wr_en, rd_en;
    logic [11:0] wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [15:0] irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [16];

    always #10 clk = ~clk;

    msi_doorbell_bank u_dut (
        .clk_i(clk), .rst_i(rst), .layout_alt_i(layout_alt), .narrow_i(narrow),
        .swap_i(swap), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic int word_of(input logic [11:0] a);
        if (narrow) begin
            if (a != 12'h038 && a % 4 == 0 && a / 4 < 8) return a / 4;
        end else begin
            if (a % 16 == 0 && a / 16 < 16) return a / 16;
        end
        return -1;
    endfunction

    function automatic bit is_doorbell(input logic [11:0] a);
        return narrow ? (a == 12'h038) : (a == 12'h140);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_irq();
        logic [15:0] r;
        for (int n = 0; n < 16; n++) r[n] = (model[n] != 0);
        return r;
    endfunction

    // One cycle: drive at a falling edge, update the model, check at the next falling edge.
    task automatic step(input bit we, input logic [11:0] wa, input logic [31:0] wd,
                        input bit re, input logic [11:0] ra, input string tag);
        logic [31:0] exp_rd;
        logic [31:0] w;
        int k, sel, bitn;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        exp_rd = 0;
        if (re) begin
            k = word_of(ra);
            if (k >= 0) begin
                exp_rd = model[k];
                model[k] = 0;
            end
        end
        if (we && is_doorbell(wa)) begin
            w = swap ? {wd[7:0], wd[15:8], wd[23:16], wd[31:24]} : wd;
            if (layout_alt) begin
                sel = w % 16; bitn = (w / 16) % 32;
            end else begin
                bitn = w % 32; sel = (w / 32) % 16;
            end
            if (sel < (narrow ? 8 : 16)) model[sel] = model[sel] | (32'd1 << bitn);
        end
        @(negedge clk);
        check(tag, rd_data, exp_rd);
        check("R7", {16'h0, irq}, {16'h0, model_irq()});
        wr_en = 0; rd_en = 0;
    endtask

    task automatic do_reset(input bit alt, input bit nar, input bit sw);
        rst = 1; layout_alt = alt; narrow = nar; swap = sw;
        wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int n = 0; n < 16; n++) model[n] = 0;
        check("R10", rd_data, 32'h0);
        check("R10", {16'h0, irq}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        // Wide stride, default layout
        do_reset(0, 0, 0);
        step(0, 0, 0, 1, 12'h000, "R10");
        step(1, 12'h140, (3 << 5) | 7, 0, 0, "R1");
        step(1, 12'h140, (3 << 5) | 0, 0, 0, "R11");
        step(1, 12'h140, (15 << 5) | 31, 0, 0, "R4");
        step(0, 0, 0, 1, 12'h030, "R1");
        step(0, 0, 0, 1, 12'h030, "R6");
        step(0, 0, 0, 1, 12'h0F0, "R4");
        step(1, 12'h010, 32'hFFFF_FFFF, 0, 0, "R9");
        step(0, 0, 0, 1, 12'h010, "R9");
        step(0, 0, 0, 1, 12'h140, "R9");
        // Collision of set and clear on word 2
        step(1, 12'h140, (2 << 5) | 1, 0, 0, "R8");
        step(1, 12'h140, (2 << 5) | 4, 1, 12'h020, "R8");
        step(0, 0, 0, 1, 12'h020, "R8");
        // Alternate layout
        do_reset(1, 0, 0);
        step(1, 12'h140, (9 << 4) | 5, 0, 0, "R2");
        step(0, 0, 0, 1, 12'h050, "R2");
        // Byte swap
        do_reset(0, 0, 1);
        step(1, 12'h140, 32'hCC00_0000, 0, 0, "R3");
        step(0, 0, 0, 1, 12'h060, "R3");
        // Narrow stride
        do_reset(0, 1, 0);
        step(1, 12'h038, (5 << 5) | 3, 0, 0, "R5");
        step(0, 0, 0, 1, 12'h014, "R5");
        step(1, 12'h038, (9 << 5) | 3, 0, 0, "R5");
        step(1, 12'h140, (1 << 5) | 3, 0, 0, "R5");
        step(0, 0, 0, 1, 12'h004, "R5");
        // Mixed traffic, model compared every cycle
        for (int mode = 0; mode < 4; mode++) begin
            do_reset(mode[0], mode[1], mode[0] ^ mode[1]);
            lfsr = 16'hACE1 ^ 16'(mode);
            for (int it = 0; it < 300; it++) begin
                logic [31:0] pl;
                logic [11:0] ra;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                pl = {23'h0, lfsr[8:0]};
                if (swap) pl = {pl[7:0], pl[15:8], pl[23:16], pl[31:24]};
                ra = narrow ? 12'(lfsr[12:10] * 4) : 12'(lfsr[13:10] * 16);
                step(lfsr[9] | lfsr[15], narrow ? 12'h038 : 12'h140, pl,
                     lfsr[14], ra, "R6");
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule